// File: doc/BRIEF.md
# Fetch-to-Decode Instruction Queue

This block is a circular instruction queue between a fetch stage that delivers groups of up to four instructions per cycle and a decode stage that can take two per cycle. Each entry carries an instruction word and the address it was fetched from. Entries leave in the order they arrived. The two oldest entries are always shown on the head slots, so decode sees the next instructions without waiting a cycle.

Fetch is throttled by free space. The ready output is high only while a whole group of four still fits, so a group is never split across cycles. When a branch turns out mispredicted or an exception is taken, the flush input empties the queue in a single cycle, discarding every speculatively fetched entry.

Top module: `fetch_iq`

## Requirements
- R1: While rst is high at a clock edge, the queue becomes empty: after that edge out_valid is 2'b00 and fetch_ready is 1.
- R2: When fetch_ready is 1 and flush is 0, the edge appends in_cnt entries taken from input slots 0, 1, 2, 3 in that order, slot 0 being oldest. An in_cnt above 4 acts as 4.
- R3: fetch_ready is 1 exactly when the occupancy is 8 or less, so at least four entries are free. A write presented while fetch_ready is 0 is ignored.
- R4: The queue holds at most 12 entries. Filling it with three groups of four drops fetch_ready to 0.
- R5: Entries leave in arrival order. Head slot 0 shows the oldest entry and head slot 1 the second oldest. Each slot carries its address and its instruction word.
- R6: out_valid[0] is 1 when at least one entry is held, and out_valid[1] is 1 when at least two are held. out_valid[1] never rises without out_valid[0].
- R7: take_cnt removes min(take_cnt, 2, occupancy) entries from the head at the edge. A take_cnt of 3 acts as 2, and taking more than is held removes only what is held.
- R8: flush has priority over any same-cycle write or take. After the edge the queue is empty: out_valid is 2'b00 and fetch_ready is 1.
- R9: When a write and a take happen at the same edge, the occupancy becomes the old occupancy plus the number written minus the number taken. Whether the write is accepted is decided on the occupancy before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all entries at this edge |
| in_cnt | input | 3 | Number of valid fetch slots, from slot 0 upward |
| in_instr | input | 4x32 | Instruction words of the four fetch slots |
| in_addr | input | 4x32 | Fetch addresses of the four fetch slots |
| take_cnt | input | 2 | Number of head entries decode takes this cycle |
| out_valid | output | 2 | Head slot valid bits |
| out_instr | output | 2x32 | Instruction words of the two oldest entries |
| out_addr | output | 2x32 | Addresses of the two oldest entries |
| fetch_ready | output | 1 | A full group of four fits |

## Verification
The bench builds the block with its default configuration: twelve entries, four-wide writes, two-wide reads and 32-bit words. With twelve entries, three groups of four fill the queue exactly. A depth that is not a power of two also makes the read and write pointers wrap past index 11 in the middle of a group, which is the path most likely to scramble order. Random phases that favour filling and then draining keep occupancy near the thresholds of 8 and 12. Directed steps cover over-range counts, a take larger than the occupancy, and a flush that coincides with a write.

// File: rtl/fiq_pkg.sv
package fiq_pkg;
    localparam int IW    = 32;
    localparam int AW    = 32;
    localparam int DEPTH = 12;
    localparam int WR_W  = 4;
    localparam int RD_W  = 2;

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int WC_W  = $clog2(WR_W + 1);
    localparam int RC_W  = $clog2(RD_W + 1);

    typedef logic [PTR_W-1:0] ptr_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [IW-1:0] instr;
    } slot_t;

    function automatic int unsigned min2(int unsigned a, int unsigned b);
        return (a < b) ? a : b;
    endfunction

    // advance a pointer around a ring of DEPTH entries (inc < DEPTH)
    function automatic ptr_t ptr_step(ptr_t p, int unsigned inc);
        int unsigned s;
        s = 32'(p) + inc;
        if (s >= DEPTH) s = s - DEPTH;
        return ptr_t'(s);
    endfunction
endpackage

// File: rtl/fiq_ctrl.sv
module fiq_ctrl
    import fiq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic [WC_W-1:0] in_cnt,
    input  logic [RC_W-1:0] take_cnt,
    output logic            fetch_ready,
    output cnt_t            wr_num,
    output ptr_t            head_ptr,
    output ptr_t            tail_ptr,
    output cnt_t            occ
);
    cnt_t rd_num;

    assign fetch_ready = (cnt_t'(DEPTH) - occ) >= cnt_t'(WR_W);

    always_comb begin
        wr_num = '0;
        rd_num = '0;
        if (!flush) begin
            if (fetch_ready)
                wr_num = cnt_t'(min2(32'(in_cnt), WR_W));
            rd_num = cnt_t'(min2(min2(32'(take_cnt), RD_W), 32'(occ)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            occ      <= '0;
        end else begin
            head_ptr <= ptr_step(head_ptr, 32'(rd_num));
            tail_ptr <= ptr_step(tail_ptr, 32'(wr_num));
            occ      <= occ + wr_num - rd_num;
        end
    end
endmodule

// File: rtl/fiq_store.sv
module fiq_store
    import fiq_pkg::*;
(
    input  logic                     clk,
    input  cnt_t                     wr_num,
    input  ptr_t                     tail_ptr,
    input  logic [WR_W-1:0][IW-1:0]  in_instr,
    input  logic [WR_W-1:0][AW-1:0]  in_addr,
    output slot_t [DEPTH-1:0]        mem_q
);
    always_ff @(posedge clk) begin
        for (int k = 0; k < WR_W; k++) begin
            if (32'(wr_num) > k) begin
                mem_q[ptr_step(tail_ptr, k)] <= '{addr: in_addr[k], instr: in_instr[k]};
            end
        end
    end
endmodule

// File: rtl/fiq_head.sv
module fiq_head
    import fiq_pkg::*;
(
    input  slot_t [DEPTH-1:0]       mem_q,
    input  ptr_t                    head_ptr,
    input  cnt_t                    occ,
    output logic [RD_W-1:0]         out_valid,
    output logic [RD_W-1:0][IW-1:0] out_instr,
    output logic [RD_W-1:0][AW-1:0] out_addr
);
    for (genvar j = 0; j < RD_W; j++) begin : g_rd
        slot_t sel;
        assign sel          = mem_q[ptr_step(head_ptr, j)];
        assign out_valid[j] = occ > cnt_t'(j);
        assign out_instr[j] = sel.instr;
        assign out_addr[j]  = sel.addr;
    end
endmodule

// File: rtl/fetch_iq.sv
module fetch_iq
    import fiq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic [WC_W-1:0]          in_cnt,
    input  logic [WR_W-1:0][IW-1:0]  in_instr,
    input  logic [WR_W-1:0][AW-1:0]  in_addr,
    input  logic [RC_W-1:0]          take_cnt,
    output logic [RD_W-1:0]          out_valid,
    output logic [RD_W-1:0][IW-1:0]  out_instr,
    output logic [RD_W-1:0][AW-1:0]  out_addr,
    output logic                     fetch_ready
);
    cnt_t              wr_num;
    ptr_t              head_ptr;
    ptr_t              tail_ptr;
    cnt_t              occ;
    slot_t [DEPTH-1:0] mem_q;

    fiq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .flush(flush), .in_cnt(in_cnt), .take_cnt(take_cnt),
        .fetch_ready(fetch_ready), .wr_num(wr_num), .head_ptr(head_ptr),
        .tail_ptr(tail_ptr), .occ(occ)
    );

    fiq_store u_store (
        .clk(clk), .wr_num(wr_num), .tail_ptr(tail_ptr),
        .in_instr(in_instr), .in_addr(in_addr), .mem_q(mem_q)
    );

    fiq_head u_head (
        .mem_q(mem_q), .head_ptr(head_ptr), .occ(occ),
        .out_valid(out_valid), .out_instr(out_instr), .out_addr(out_addr)
    );
endmodule

// File: rtl/fiq_chk.sv
module fiq_chk
    import fiq_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     flush,
    input logic [RC_W-1:0]          take_cnt,
    input logic [RD_W-1:0]          out_valid,
    input logic [RD_W-1:0][IW-1:0]  out_instr,
    input logic                     fetch_ready,
    input cnt_t                     occ
);
    // R1
    reset_empty_chk: assert property (@(posedge clk)
        rst |=> (out_valid == '0 && fetch_ready));

    // R6
    valid_order_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid[1] |-> out_valid[0]);

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (out_valid == '0 && fetch_ready));

    // R4
    capacity_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= cnt_t'(DEPTH));

    // R3
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fetch_ready && !flush && take_cnt == '0) |=> !fetch_ready);

    // R5
    head_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid[1] && take_cnt == RC_W'(1) && !flush)
        |=> (out_valid[0] && out_instr[0] == $past(out_instr[1])));
endmodule

bind fetch_iq fiq_chk chk_i (
    .clk(clk), .rst(rst), .flush(flush), .take_cnt(take_cnt),
    .out_valid(out_valid), .out_instr(out_instr),
    .fetch_ready(fetch_ready), .occ(occ)
);

// File: tb/fetch_iq_tb_top.sv
`timescale 1ns/1ps
module fetch_iq_tb_top;
    import fiq_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    flush = 1'b0;
    logic [WC_W-1:0]         in_cnt = '0;
    logic [WR_W-1:0][IW-1:0] in_instr = '0;
    logic [WR_W-1:0][AW-1:0] in_addr = '0;
    logic [RC_W-1:0]         take_cnt = '0;
    logic [RD_W-1:0]         out_valid;
    logic [RD_W-1:0][IW-1:0] out_instr;
    logic [RD_W-1:0][AW-1:0] out_addr;
    logic                    fetch_ready;

    int checks = 0;
    int errors = 0;
    logic [AW+IW-1:0] mq[$];
    int unsigned seq = 0;

    always #4 clk = ~clk;

    fetch_iq dut_i (
        .clk(clk), .rst(rst), .flush(flush), .in_cnt(in_cnt), .in_instr(in_instr),
        .in_addr(in_addr), .take_cnt(take_cnt), .out_valid(out_valid),
        .out_instr(out_instr), .out_addr(out_addr), .fetch_ready(fetch_ready)
    );

    function automatic int unsigned imin(int unsigned a, int unsigned b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic exp_ready(int unsigned size);
        return (DEPTH - size) >= WR_W;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        for (int j = 0; j < RD_W; j++) begin
            logic ev;
            ev = mq.size() > j;
            chk({tag, " R6 valid"}, 64'(out_valid[j]), 64'(ev));
            if (ev) chk({tag, " R5 head"}, 64'({out_addr[j], out_instr[j]}), 64'(mq[j]));
        end
        chk({tag, " R3 ready"}, 64'(fetch_ready), 64'(exp_ready(mq.size())));
    endtask

    // called at a negedge: drive, update the model to the post-edge state, check at next negedge
    task automatic step(int unsigned n, int unsigned tk, logic fl, string tag);
        int unsigned sz, w, r;
        in_cnt   = WC_W'(n);
        take_cnt = RC_W'(tk);
        flush    = fl;
        for (int k = 0; k < WR_W; k++) begin
            in_instr[k] = $urandom;
            in_addr[k]  = seq * 4;
            seq++;
        end
        sz = mq.size();
        if (fl) begin
            mq.delete();
        end else begin
            r = imin(imin(tk, RD_W), sz);
            w = exp_ready(sz) ? imin(n, WR_W) : 0;
            for (int i = 0; i < int'(r); i++) void'(mq.pop_front());
            for (int k = 0; k < int'(w); k++) mq.push_back({in_addr[k], in_instr[k]});
        end
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int mode;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: state after reset
        chk("R1 valid", 64'(out_valid), 64'd0);
        chk("R1 ready", 64'(fetch_ready), 64'd1);

        step(4, 0, 1'b0, "R2");
        step(4, 0, 1'b0, "R2");
        step(4, 0, 1'b0, "R4");
        chk("R4 full", 64'(fetch_ready), 64'd0);
        step(4, 0, 1'b0, "R3");             // ignored while not ready
        step(0, 2, 1'b0, "R5");             // 10 left
        step(4, 2, 1'b0, "R9");             // not ready: 8
        step(4, 2, 1'b0, "R9");             // 8 + 4 - 2 = 10
        chk("R9 occupancy", 64'(mq.size()), 64'd10);
        step(4, 1, 1'b1, "R8");             // flush beats write and take
        chk("R8 empty", 64'(out_valid), 64'd0);
        step(7, 0, 1'b0, "R2");             // clamps to 4
        step(0, 3, 1'b0, "R7");             // 3 acts as 2
        step(0, 3, 1'b0, "R7");
        step(1, 2, 1'b0, "R7");             // take from empty, write one
        chk("R7 single", 64'(out_valid), 64'd1);
        step(0, 0, 1'b1, "R8");

        mode = 0;
        for (int c = 0; c < 4000; c++) begin
            int unsigned n, tk;
            logic fl;
            if (c % 64 == 0) mode = $urandom_range(0, 2);
            n  = $urandom_range(0, 5);
            tk = $urandom_range(0, 3);
            if (mode == 0 && $urandom_range(0, 3) != 0) tk = 0;
            if (mode == 1 && $urandom_range(0, 3) != 0) n = 0;
            fl = ($urandom_range(0, 40) == 0);
            step(n, tk, fl, "R9");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule